// File: doc/BRIEF.md
# Vector element loop sequencer

This block sits between instruction decode and the execution units. When a decoded scalar operation names at least one operand marked as a vector, the block expands it into a series of element operations. It holds the program counter for the whole expansion. Vector operands step through consecutive register numbers and scalar operands stay fixed. It can issue at most one element per clock, and it issues them in element order.

Each element is gated by one bit of a predicate mask. A masked element is either skipped or turned into a write-zero request, depending on the zeroing flag. A fail-on-first flag lets a zero result shorten the vector length. An exception stops the loop without moving its element and sub-element offsets, so the next start resumes at the element that faulted. The execution unit answers each issued element in the same cycle through the `rsp_zero` and `rsp_exc` inputs.

Top module: `vec_elem_seq`

## Requirements
- R1: A `start` seen while idle is captured at the clock edge, and `hold_pc` is high from the next cycle. It stays high until the cycle in which `done` or `trap` pulses. Elements are handled at one per cycle in rising element order.
- R2: For element e and sub-element s, the register number of a vector operand is base + e*S + s, modulo 2^REG_W, where S is the group size. A scalar operand uses its base register for every element.
- R3: `subvl_enc` values 0, 1, 2 and 3 select groups of 1, 2, 3 and 4 sub-elements. Mask bit e (bit e of `pred_mask`) gates the whole group of element e.
- R4: When the destination is scalar, the loop ends with `done` in the cycle that completes the first group whose mask bit is set.
- R5: With zeroing off, an element whose mask bit is clear issues nothing. It uses one cycle, and the element offset still advances.
- R6: With zeroing on and fail-on-first off, an element whose mask bit is clear raises `issue_zero` once per sub-element, carrying the destination register number from R2.
- R7: `rsp_exc` on an issued element pulses `trap` and leaves `elem_off` and `sub_off` unchanged. The next start resumes at those offsets.
- R8: When the last element (index VL-1) completes, `done` pulses, and `elem_off` and `sub_off` return to zero.
- R9: With fail-on-first set, `rsp_zero` on an issued element e ends the loop. `done` pulses together with `vl_upd_valid`, and `vl_upd` equals e.
- R10: With fail-on-first and zeroing both set, the first element whose mask bit is clear ends the loop with `vl_upd` equal to its index and nothing issued for it. With fail-on-first and zeroing off, masked elements are never tested.
- R11: When `vl_en` is 0 or no operand is marked vector, exactly one operation issues on the base registers. The predicate is ignored and the saved offsets are left untouched.
- R12: After reset, `hold_pc`, `issue_valid`, `issue_zero`, `done` and `trap` are low, and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | New decoded operation present |
| vl_en | input | 1 | Vector length register is not x0 |
| vl_len | input | VL_W | Vector length, 1 to MAXVL |
| subvl_enc | input | 2 | Group size minus one |
| rd | input | REG_W | Destination base register |
| rs1 | input | REG_W | First source base register |
| rs2 | input | REG_W | Second source base register |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | First source is a vector |
| rs2_vec | input | 1 | Second source is a vector |
| pred_mask | input | MAXVL | Predicate, one bit per element |
| pred_zero | input | 1 | Zeroing mode |
| pred_ffirst | input | 1 | Fail-on-first mode |
| rsp_zero | input | 1 | Issued element produced a zero result |
| rsp_exc | input | 1 | Issued element raised an exception |
| hold_pc | output | 1 | Program counter must not advance |
| issue_valid | output | 1 | Element operation issued this cycle |
| issue_zero | output | 1 | Write-zero request this cycle |
| issue_rd | output | REG_W | Destination register of this element |
| issue_rs1 | output | REG_W | First source register of this element |
| issue_rs2 | output | REG_W | Second source register of this element |
| done | output | 1 | Loop finished this cycle |
| trap | output | 1 | Loop stopped by an exception this cycle |
| vl_upd_valid | output | 1 | Vector length shortened by fail-on-first |
| vl_upd | output | VL_W | New vector length |
| elem_off | output | EI_W | Saved element offset |
| sub_off | output | 2 | Saved sub-element offset |

## Verification
The hardest case to reach from the ports is a resume in the middle of a group. An exception has to land on a non-zero sub-element, and then an unrelated scalar operation has to pass through before the loop restarts. The bench drives `rsp_exc` for one chosen element and sub-element of a grouped operation and checks the saved offsets. It then runs a pass-through operation and checks the offsets again. Finally it restarts the same operation and expects the element stream to continue from that sub-element.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    ACT_SKIP  = 2'd0,
    ACT_ISSUE = 2'd1,
    ACT_ZERO  = 2'd2,
    ACT_CUT   = 2'd3
  } elem_act_e;

  function automatic logic [2:0] grp_size(input logic [1:0] enc);
    return {1'b0, enc} + 3'd1;
  endfunction

endpackage

// File: rtl/vseq_opaddr.sv
module vseq_opaddr #(
  parameter int REG_W = 7,
  parameter int EI_W  = 3
) (
  input  logic [REG_W-1:0] base,
  input  logic             is_vec,
  input  logic [EI_W-1:0]  elem,
  input  logic [1:0]       sub,
  input  logic [2:0]       sub_n,
  output logic [REG_W-1:0] addr
);
  localparam int OW = EI_W + 3;

  function automatic logic [REG_W-1:0] step_addr(
    input logic [REG_W-1:0] b, input logic [EI_W-1:0] e,
    input logic [1:0] s, input logic [2:0] n);
    logic [OW-1:0] off;
    off = OW'(e) * OW'(n) + OW'(s);
    return b + REG_W'(off);
  endfunction

  assign addr = is_vec ? step_addr(base, elem, sub, sub_n) : base;
endmodule

// File: rtl/vseq_pred.sv
module vseq_pred
  import vseq_pkg::*;
(
  input  logic      mask_bit,
  input  logic      zeroing,
  input  logic      ffirst,
  output elem_act_e act
);
  always_comb begin
    if (mask_bit)            act = ACT_ISSUE;
    else if (zeroing && ffirst) act = ACT_CUT;
    else if (zeroing)        act = ACT_ZERO;
    else                     act = ACT_SKIP;
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int REG_W = 7,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int EI_W = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vl_en,
  input  logic [VL_W-1:0]  vl_len,
  input  logic [1:0]       subvl_enc,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic             rd_vec,
  input  logic             rs1_vec,
  input  logic             rs2_vec,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             pred_zero,
  input  logic             pred_ffirst,
  input  logic             rsp_zero,
  input  logic             rsp_exc,
  output logic             hold_pc,
  output logic             issue_valid,
  output logic             issue_zero,
  output logic [REG_W-1:0] issue_rd,
  output logic [REG_W-1:0] issue_rs1,
  output logic [REG_W-1:0] issue_rs2,
  output logic             done,
  output logic             trap,
  output logic             vl_upd_valid,
  output logic [VL_W-1:0]  vl_upd,
  output logic [EI_W-1:0]  elem_off,
  output logic [1:0]       sub_off
);
  localparam int NOPS = 3;

  logic             busy_q, pass_q, zer_q, ff_q;
  logic [VL_W-1:0]  vl_q;
  logic [2:0]       subn_q;
  logic [MAXVL-1:0] mask_q;
  logic [REG_W-1:0] base_q [NOPS];
  logic [NOPS-1:0]  vec_q;
  logic [EI_W-1:0]  elem_q;
  logic [1:0]       sub_q;

  logic             take, is_pass;
  logic [EI_W-1:0]  e_cur;
  logic [1:0]       s_cur;
  elem_act_e        act;
  logic             last_sub, last_elem, grp_end;
  logic             ev_exc, ev_cut, ev_fin, ev_step;
  logic [REG_W-1:0] addr_arr [NOPS];

  assign take    = start && !busy_q;
  assign is_pass = !vl_en || !(rd_vec || rs1_vec || rs2_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; pass_q <= 1'b0; zer_q <= 1'b0; ff_q <= 1'b0;
      vl_q   <= '0;   subn_q <= 3'd1; mask_q <= '0;  vec_q <= '0;
      for (int i = 0; i < NOPS; i++) base_q[i] <= '0;
    end else if (take) begin
      busy_q    <= 1'b1;
      pass_q    <= is_pass;
      zer_q     <= pred_zero && !is_pass;
      ff_q      <= pred_ffirst && !is_pass;
      vl_q      <= is_pass ? VL_W'(1) : vl_len;
      subn_q    <= is_pass ? 3'd1 : grp_size(subvl_enc);
      mask_q    <= is_pass ? '1 : pred_mask;
      vec_q     <= is_pass ? '0 : {rs2_vec, rs1_vec, rd_vec};
      base_q[0] <= rd;
      base_q[1] <= rs1;
      base_q[2] <= rs2;
    end else if (done || trap) begin
      busy_q <= 1'b0;
    end
  end

  assign e_cur = pass_q ? '0 : elem_q;
  assign s_cur = pass_q ? '0 : sub_q;

  vseq_pred u_pred (
    .mask_bit (mask_q[e_cur]),
    .zeroing  (zer_q),
    .ffirst   (ff_q),
    .act      (act)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    vseq_opaddr #(.REG_W(REG_W), .EI_W(EI_W)) u_addr (
      .base   (base_q[g]),
      .is_vec (vec_q[g]),
      .elem   (e_cur),
      .sub    (s_cur),
      .sub_n  (subn_q),
      .addr   (addr_arr[g])
    );
  end

  assign last_sub  = ({1'b0, s_cur} == (subn_q - 3'd1));
  assign last_elem = (VL_W'(e_cur) == (vl_q - VL_W'(1)));

  assign issue_valid = busy_q && (act == ACT_ISSUE);
  assign issue_zero  = busy_q && (act == ACT_ZERO);
  assign issue_rd    = addr_arr[0];
  assign issue_rs1   = addr_arr[1];
  assign issue_rs2   = addr_arr[2];

  assign ev_exc  = issue_valid && rsp_exc;
  assign ev_cut  = busy_q && ((act == ACT_CUT) ||
                              (issue_valid && !rsp_exc && ff_q && rsp_zero));
  assign grp_end = (act == ACT_SKIP) ||
                   (last_sub && (act == ACT_ZERO || (act == ACT_ISSUE && !rsp_exc)));
  assign ev_fin  = busy_q && !ev_exc && !ev_cut && grp_end &&
                   (last_elem || (act == ACT_ISSUE && !vec_q[0]));
  assign ev_step = busy_q && !ev_exc && !ev_cut && !ev_fin && !pass_q;

  assign done         = ev_fin || ev_cut;
  assign trap         = ev_exc;
  assign vl_upd_valid = ev_cut;
  assign vl_upd       = VL_W'(e_cur);
  assign hold_pc      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else if (done && !pass_q) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else if (ev_step) begin
      if (grp_end) begin
        elem_q <= elem_q + EI_W'(1);
        sub_q  <= '0;
      end else begin
        sub_q  <= sub_q + 2'd1;
      end
    end
  end

  assign elem_off = elem_q;
  assign sub_off  = sub_q;

  // R1
  end_drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap) |=> !hold_pc);

  // R1
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pc && $past(hold_pc)) |-> (elem_off >= $past(elem_off)));

  // R7
  trap_keeps_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> ($stable(elem_off) && $stable(sub_off)));

  // R8
  finish_clears_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass_q) |=> (elem_off == '0 && sub_off == '0));

  // R9
  cut_shorter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_upd_valid |-> (done && vl_upd < vl_q));

  // R11
  pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pc && pass_q && issue_valid) |-> (done || trap));
endmodule

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;
  localparam int MAXVL = 8;
  localparam int REG_W = 7;
  localparam int VL_W  = $clog2(MAXVL + 1);
  localparam int EI_W  = $clog2(MAXVL);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, vl_en = 0, rd_vec = 0, rs1_vec = 0, rs2_vec = 0;
  logic pred_zero = 0, pred_ffirst = 0, rsp_zero = 0, rsp_exc = 0;
  logic [VL_W-1:0]  vl_len = '0;
  logic [1:0]       subvl_enc = '0;
  logic [REG_W-1:0] rd = '0, rs1 = '0, rs2 = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic hold_pc, issue_valid, issue_zero, done, trap, vl_upd_valid;
  logic [REG_W-1:0] issue_rd, issue_rs1, issue_rs2;
  logic [VL_W-1:0]  vl_upd;
  logic [EI_W-1:0]  elem_off;
  logic [1:0]       sub_off;

  vec_elem_seq #(.MAXVL(MAXVL), .REG_W(REG_W)) u_dut (.*);

  int chk = 0, err = 0;
  logic [22:0] exp_q [$];
  int exc_e = 0, exc_s = 0, zero_e = 0, zero_s = 0;
  bit exc_en = 0, zero_en = 0;
  bit end_seen = 0, end_trap = 0, end_cut = 0;
  int end_vl = 0;
  string cur_req = "R1";

  function automatic logic [22:0] mk(int kind, int a, int b, int c);
    return {2'(kind), 7'(a), 7'(b), 7'(c)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops scoreboard items as elements appear, drives responses
  always begin
    @(negedge clk);
    rsp_exc  = exc_en  && (int'(elem_off) == exc_e)  && (int'(sub_off) == exc_s);
    rsp_zero = zero_en && (int'(elem_off) == zero_e) && (int'(sub_off) == zero_s);
    if (issue_valid || issue_zero) begin
      logic [22:0] got;
      got = issue_valid ? mk(1, issue_rd, issue_rs1, issue_rs2) : mk(2, issue_rd, 0, 0);
      if (exp_q.size() == 0) check(0, cur_req, "unexpected element", int'(got), 0);
      else begin
        logic [22:0] want;
        want = exp_q.pop_front();
        check(got == want, cur_req, "element item", int'(got), int'(want));
      end
    end
    #1;
    if (done || trap) begin
      end_seen = 1; end_trap = trap; end_cut = vl_upd_valid; end_vl = int'(vl_upd);
    end
  end

  task automatic run_op(string req, bit ven, int vl, int senc, int a, int b, int c,
                        bit dv, bit v1, bit v2, logic [7:0] mask, bit zer, bit ff,
                        int e0, int s0);
    bit pass, fin, p, exp_trap;
    int n, exp_cut, guard;
    cur_req = req;
    pass = !ven || !(dv || v1 || v2);
    n = senc + 1;
    exp_trap = 0; exp_cut = -1; fin = 0;
    if (pass) begin
      exp_q.push_back(mk(1, a, b, c));
    end else begin
      for (int e = e0; e < vl && !fin; e++) begin
        p = mask[e];
        if (!p && !zer) continue;
        if (!p && zer && ff) begin exp_cut = e; fin = 1; break; end
        for (int s = (e == e0 ? s0 : 0); s < n; s++) begin
          int ad, b1, c2;
          ad = dv ? a + e*n + s : a;
          b1 = v1 ? b + e*n + s : b;
          c2 = v2 ? c + e*n + s : c;
          if (p) begin
            exp_q.push_back(mk(1, ad, b1, c2));
            if (exc_en && e == exc_e && s == exc_s) begin exp_trap = 1; fin = 1; break; end
            if (ff && zero_en && e == zero_e && s == zero_s) begin exp_cut = e; fin = 1; break; end
          end else begin
            exp_q.push_back(mk(2, ad, 0, 0));
          end
        end
        if (!fin && p && !dv) fin = 1;
      end
    end
    end_seen = 0;
    @(negedge clk);
    start = 1; vl_en = ven; vl_len = VL_W'(vl); subvl_enc = 2'(senc);
    rd = 7'(a); rs1 = 7'(b); rs2 = 7'(c);
    rd_vec = dv; rs1_vec = v1; rs2_vec = v2;
    pred_mask = mask; pred_zero = zer; pred_ffirst = ff;
    @(negedge clk);
    start = 0;
    check(hold_pc == 1'b1, "R1", "hold_pc after start", int'(hold_pc), 1);
    guard = 0;
    while (!end_seen && guard < 100) begin @(posedge clk); guard++; end
    @(negedge clk);
    check(end_seen, req, "loop ended", int'(end_seen), 1);
    check(end_trap == exp_trap, req, "trap outcome", int'(end_trap), int'(exp_trap));
    check(end_cut == (exp_cut >= 0), req, "vl cut flag", int'(end_cut), int'(exp_cut >= 0));
    if (exp_cut >= 0) check(end_vl == exp_cut, req, "new vl", end_vl, exp_cut);
    check(exp_q.size() == 0, req, "items left", exp_q.size(), 0);
    check(hold_pc == 1'b0, "R1", "hold_pc after end", int'(hold_pc), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", err, chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!hold_pc && !issue_valid && !issue_zero && !done && !trap, "R12", "idle outputs",
          int'({hold_pc, issue_valid, issue_zero, done, trap}), 0);
    check(elem_off == 0 && sub_off == 0, "R12", "offsets", int'({elem_off, sub_off}), 0);
    rst_n = 1;
    @(negedge clk);

    // R11 pass-through: VL register is x0
    run_op("R11", 0, 4, 1, 5, 6, 7, 1, 1, 0, 8'h00, 1, 1, 0, 0);
    // R2 R8 all vector, full mask
    run_op("R2", 1, 4, 0, 10, 20, 30, 1, 1, 1, 8'hFF, 0, 0, 0, 0);
    check(elem_off == 0 && sub_off == 0, "R8", "offsets after done", int'({elem_off, sub_off}), 0);
    // R3 groups of three, scalar rs2
    run_op("R3", 1, 5, 2, 40, 1, 9, 1, 1, 0, 8'hFF, 0, 0, 0, 0);
    // R5 skip masked elements
    run_op("R5", 1, 4, 0, 12, 24, 3, 1, 1, 0, 8'b1010, 0, 0, 0, 0);
    // R6 zeroing writes, groups of two
    run_op("R6", 1, 4, 1, 50, 60, 2, 1, 0, 1, 8'b0110, 1, 0, 0, 0);
    // R4 scalar destination ends after first passing element
    run_op("R4", 1, 4, 0, 3, 16, 5, 0, 1, 0, 8'b1100, 0, 0, 0, 0);
    // R9 fail-on-first, zero result at element 2
    zero_en = 1; zero_e = 2; zero_s = 0;
    run_op("R9", 1, 6, 0, 8, 16, 24, 1, 1, 0, 8'hFF, 0, 1, 0, 0);
    // R10 fail-on-first non-zeroing: masked element 1 with zero pending not tested
    zero_e = 1;
    run_op("R10", 1, 4, 0, 8, 16, 24, 1, 1, 0, 8'b1101, 0, 1, 0, 0);
    zero_en = 0;
    // R10 fail-on-first with zeroing: first masked element cuts
    run_op("R10", 1, 4, 0, 30, 40, 50, 1, 0, 1, 8'b1101, 1, 1, 0, 0);
    // R7 exception at element 2 sub-element 1
    exc_en = 1; exc_e = 2; exc_s = 1;
    run_op("R7", 1, 4, 1, 20, 70, 4, 1, 1, 0, 8'hFF, 0, 0, 0, 0);
    check(elem_off == 2, "R7", "saved element offset", int'(elem_off), 2);
    check(sub_off == 1, "R7", "saved sub offset", int'(sub_off), 1);
    exc_en = 0;
    // R11 scalar op between trap and resume leaves offsets
    run_op("R11", 1, 4, 0, 1, 2, 3, 0, 0, 0, 8'h00, 1, 0, 0, 0);
    check(elem_off == 2 && sub_off == 1, "R11", "offsets kept", int'({elem_off, sub_off}), 9);
    // R7 resume from saved offsets
    run_op("R7", 1, 4, 1, 20, 70, 4, 1, 1, 0, 8'hFF, 0, 0, 2, 1);
    check(elem_off == 0 && sub_off == 0, "R8", "offsets after resume", int'({elem_off, sub_off}), 0);
    // R2 wrap of register number
    run_op("R2", 1, 8, 3, 120, 0, 0, 1, 0, 0, 8'hFF, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", err, chk);
    $finish;
  end
endmodule